// File: doc/BRIEF.md
# Power-Down Freeze Unit

This block sits between the device pins and a programmable logic core. One pin is shared: a configuration bit makes it either a power-down request or one more logic input. When power-down is enabled and the pin is high, the unit stops every input, clock and output-enable change from reaching the core. It also holds every value it drives out to the pins, including outputs that are in the high-impedance state. The core's own registers keep their state because the unit never issues a clock enable to them. The core clock itself is never gated.

All pins are sampled on the system clock `clk`. A rising level on the pin-side clock becomes a one-cycle clock-enable pulse (`core_tick`) to the core. When the request pin falls, the unit recovers in two steps, both counted in system cycles. Inputs, the clock and the output enable are passed to the core again after `CTL_DLY` cycles. Output updates resume after the longer `OUT_DLY` cycles. The parameters must satisfy 1 <= `CTL_DLY` < `OUT_DLY`.

Top module: `pdf_freeze_unit`

## Requirements
- R1: While `rst_n` is low on a clock edge, that edge clears `core_in`, `core_tick`, `core_oe_en`, `pin_out` and `pin_oe` to zero, and both recovery steps count as complete.
- R2: With `pd_mode_en` low, the shared pin is an ordinary input. Bit `N_IN` of `core_in` shows the value `pd_pin` had at the previous edge, and nothing is ever frozen.
- R3: Outside power-down and recovery, the unit is a one-cycle pipeline. `in_pins` goes to `core_in[N_IN-1:0]`, `oe_pin` to `core_oe_en`, `core_out` to `pin_out` and `core_oe` to `pin_oe`. While `pd_mode_en` is high, `core_in[N_IN]` reads 0.
- R4: An edge that samples `clk_pin` high, when the previous edge sampled it low, produces `core_tick` = 1 for exactly the following cycle.
- R5: On every edge that samples `pd_mode_en` and `pd_pin` both high, `pin_out` and `pin_oe` keep their values.
- R6: An output whose `pin_oe` bit was 0 (high impedance) when power-down began reads 0 until outputs are released, even if `core_oe` drives that bit to 1 meanwhile.
- R7: During power-down, `core_in` and `core_oe_en` hold their values and `core_tick` stays 0, whatever `in_pins`, `clk_pin` and `oe_pin` do.
- R8: If `clk_pin` rises during power-down or early recovery, no `core_tick` pulse is issued for that rise at any later time.
- R9: After the pin falls, the first `CTL_DLY` edges that sample it low still ignore `in_pins`, `clk_pin` and `oe_pin`. The first `OUT_DLY` such edges still hold `pin_out` and `pin_oe`.
- R10: A high level on the pin during recovery cancels the recovery in progress. Counting starts again from zero at the next fall.
- R11: An input change applied in the same cycle as the pin's rise is not passed to the core, and an output change from the core in that cycle does not reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_mode_en | input | 1 | Configuration bit: 1 makes `pd_pin` the power-down request |
| pd_pin | input | 1 | Shared pin: power-down request, or a plain logic input |
| in_pins | input | N_IN | Logic input pins |
| clk_pin | input | 1 | Pin-side clock for the core registers |
| oe_pin | input | 1 | Common output-enable pin |
| core_out | input | N_OUT | Output values from the core |
| core_oe | input | N_OUT | Per-output enables from the core |
| core_in | output | N_IN+1 | Gated inputs to the core; the top bit carries the shared pin |
| core_tick | output | 1 | One-cycle clock enable for the core registers |
| core_oe_en | output | 1 | Gated common output enable to the core |
| pin_out | output | N_OUT | Held output values toward the pins |
| pin_oe | output | N_OUT | Held output enables toward the pins; 0 means high impedance |

## Verification
The assertions check on every clock cycle the properties that depend on a single edge. These are:
- an active request edge leaves the pin-side outputs, the core inputs and the output enable unchanged, and issues no tick;
- outputs are never released before the control signals;
- a release is only ever withdrawn by a power-down request;
- a tick lasts exactly one cycle;
- the shared pin passes straight through when the mode is off.

Only the directed scenarios can show behaviour that spans several cycles:
- the exact recovery cycle counts;
- the restart of recovery when the pin pulses again;
- an input change arriving together with the pin's rise being lost;
- a clock rise that happened during power-down never being delivered after wake-up.

// File: rtl/pdf_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the power-down freeze unit.
// Assumes nothing beyond SystemVerilog packed structs.
package pdf_pkg;

    // Gate controls handed from the wake controller to the datapath gates.
    typedef struct packed {
        logic ctl_open;   // inputs, pin clock and OE may reach the core
        logic out_open;   // core outputs may reach the pins
    } pdf_gate_t;

endpackage

// File: rtl/pdf_wake_ctrl.sv
`timescale 1ns/1ps
// Wake controller: decides, from the mode bit and the request pin, when
// inputs and outputs are blocked. It also counts the two-step recovery
// after the request falls.
// Assumes 1 <= CTL_DLY < OUT_DLY; the pins are already synchronous to clk.
module pdf_wake_ctrl
    import pdf_pkg::*;
#(
    parameter int CTL_DLY = 2,
    parameter int OUT_DLY = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_mode_en,
    input  logic      pd_pin,
    output pdf_gate_t gate
);

    localparam int CNT_W = $clog2(OUT_DLY + 1);
    localparam logic [CNT_W-1:0] CTL_LIM = CNT_W'(CTL_DLY);
    localparam logic [CNT_W-1:0] OUT_LIM = CNT_W'(OUT_DLY);

    logic [CNT_W-1:0] wake_cnt;
    logic [CNT_W-1:0] wake_cnt_nxt;
    logic             ctl_rel_q;
    logic             out_rel_q;

    // Next count value while recovering.
    assign wake_cnt_nxt = wake_cnt + CNT_W'(1);

    // Recovery counter and release flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_mode_en) begin
            wake_cnt  <= '0;
            ctl_rel_q <= 1'b1;
            out_rel_q <= 1'b1;
        end else if (pd_pin) begin
            wake_cnt  <= '0;
            ctl_rel_q <= 1'b0;
            out_rel_q <= 1'b0;
        end else if (!out_rel_q) begin
            wake_cnt  <= wake_cnt_nxt;
            ctl_rel_q <= (wake_cnt_nxt >= CTL_LIM);
            out_rel_q <= (wake_cnt_nxt >= OUT_LIM);
        end
    end

    // Gates: an active request blocks at once; otherwise the release flags decide.
    always_comb begin
        gate.ctl_open = !pd_mode_en || (!pd_pin && ctl_rel_q);
        gate.out_open = !pd_mode_en || (!pd_pin && out_rel_q);
    end

    // R9
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_rel_q |-> ctl_rel_q);

    // R10
    release_revoke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rel_q) |-> $past(pd_mode_en && pd_pin));

endmodule

// File: rtl/pdf_in_gate.sv
`timescale 1ns/1ps
// Input gate: captures the input pins, the shared pin, the OE pin and the
// pin-side clock for the core, but only while the controller opens the gate.
// The pin clock level is always tracked, so a rise seen while blocked is
// never delivered later.
// Assumes the pins are sampled synchronously on clk.
module pdf_in_gate
    import pdf_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pdf_gate_t     gate,
    input  logic          pd_mode_en,
    input  logic          pd_pin,
    input  logic [N_IN-1:0] in_pins,
    input  logic          clk_pin,
    input  logic          oe_pin,
    output logic [N_IN:0] core_in,
    output logic          core_tick,
    output logic          core_oe_en
);

    logic [N_IN-1:0] in_q;
    logic            shared_q;
    logic            oe_q;
    logic            clkp_q;
    logic            tick_q;

    // Data inputs and OE: capture when open, hold when blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q     <= '0;
            shared_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (gate.ctl_open) begin
            in_q     <= in_pins;
            shared_q <= !pd_mode_en && pd_pin;
            oe_q     <= oe_pin;
        end
    end

    // Pin clock: always track the level; pulse the enable only on an open rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clkp_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            clkp_q <= clk_pin;
            tick_q <= gate.ctl_open && clk_pin && !clkp_q;
        end
    end

    assign core_in    = {shared_q, in_q};
    assign core_tick  = tick_q;
    assign core_oe_en = oe_q;

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |=> !core_tick);

    // R2
    shared_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_mode_en |=> core_in[N_IN] == $past(pd_pin));

endmodule

// File: rtl/pdf_out_hold.sv
`timescale 1ns/1ps
// Output hold: one register pair per output (value and enable). Each pair
// follows the core while outputs are open and keeps its value otherwise.
// Held enables also keep high-impedance outputs high impedance.
// Assumes core_out/core_oe are synchronous to clk.
module pdf_out_hold
    import pdf_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pdf_gate_t        gate,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_slice
        logic val_q;
        logic en_q;

        // Per-output hold register: load when open, keep when frozen.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= 1'b0;
                en_q  <= 1'b0;
            end else if (gate.out_open) begin
                val_q <= core_out[i];
                en_q  <= core_oe[i];
            end
        end

        assign pin_out[i] = val_q;
        assign pin_oe[i]  = en_q;
    end

    // R3
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate.out_open |=> (pin_out == $past(core_out)) && (pin_oe == $past(core_oe)));

endmodule

// File: rtl/pdf_freeze_unit.sv
`timescale 1ns/1ps
// Power-down freeze unit (top). Connects the wake controller, the input gate
// and the output hold. With the mode bit set and the shared pin high, the
// core sees no input, clock or OE change and the pins hold their values.
// Assumes all pins are synchronous to clk and 1 <= CTL_DLY < OUT_DLY.
module pdf_freeze_unit
    import pdf_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int N_OUT   = 8,
    parameter int CTL_DLY = 2,
    parameter int OUT_DLY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_mode_en,
    input  logic             pd_pin,
    input  logic [N_IN-1:0]  in_pins,
    input  logic             clk_pin,
    input  logic             oe_pin,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_IN:0]    core_in,
    output logic             core_tick,
    output logic             core_oe_en,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe
);

    pdf_gate_t gate;

    pdf_wake_ctrl #(.CTL_DLY(CTL_DLY), .OUT_DLY(OUT_DLY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_mode_en (pd_mode_en),
        .pd_pin     (pd_pin),
        .gate       (gate)
    );

    pdf_in_gate #(.N_IN(N_IN)) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (gate),
        .pd_mode_en (pd_mode_en),
        .pd_pin     (pd_pin),
        .in_pins    (in_pins),
        .clk_pin    (clk_pin),
        .oe_pin     (oe_pin),
        .core_in    (core_in),
        .core_tick  (core_tick),
        .core_oe_en (core_oe_en)
    );

    pdf_out_hold #(.N_OUT(N_OUT)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    // R5
    freeze_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode_en && pd_pin) |=> $stable(pin_out) && $stable(pin_oe));

    // R7
    freeze_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode_en && pd_pin) |=> $stable(core_in) && $stable(core_oe_en) && !core_tick);

endmodule

// File: tb/pdf_freeze_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for the power-down freeze unit; one task per scenario.
module pdf_freeze_unit_bench;

    localparam int N_IN    = 8;
    localparam int N_OUT   = 8;
    localparam int CTL_DLY = 2;
    localparam int OUT_DLY = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pd_mode_en = 1'b1;
    logic             pd_pin = 1'b0;
    logic [N_IN-1:0]  in_pins = '0;
    logic             clk_pin = 1'b0;
    logic             oe_pin = 1'b0;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_OUT-1:0] core_oe = '0;
    logic [N_IN:0]    core_in;
    logic             core_tick;
    logic             core_oe_en;
    logic [N_OUT-1:0] pin_out;
    logic [N_OUT-1:0] pin_oe;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pdf_freeze_unit #(.N_IN(N_IN), .N_OUT(N_OUT), .CTL_DLY(CTL_DLY), .OUT_DLY(OUT_DLY))
    u_pdf_freeze_unit (
        .clk(clk), .rst_n(rst_n), .pd_mode_en(pd_mode_en), .pd_pin(pd_pin),
        .in_pins(in_pins), .clk_pin(clk_pin), .oe_pin(oe_pin),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .core_tick(core_tick), .core_oe_en(core_oe_en),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1 core_in", 32'(core_in), 32'h0);
        chk("R1 core_tick", 32'(core_tick), 32'h0);
        chk("R1 core_oe_en", 32'(core_oe_en), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_pass();
        in_pins = 8'hA5; core_out = 8'h3C; core_oe = 8'hF0; oe_pin = 1'b1;
        step(1);
        chk("R3 core_in a", 32'(core_in), 32'h0A5);
        chk("R3 pin_out a", 32'(pin_out), 32'h3C);
        chk("R3 pin_oe a", 32'(pin_oe), 32'hF0);
        chk("R3 oe_en a", 32'(core_oe_en), 32'h1);
        in_pins = 8'h5A; core_out = 8'hC3; core_oe = 8'h0F; oe_pin = 1'b0;
        step(1);
        chk("R3 core_in b", 32'(core_in), 32'h05A);
        chk("R3 pin_out b", 32'(pin_out), 32'hC3);
        chk("R3 pin_oe b", 32'(pin_oe), 32'h0F);
        chk("R3 oe_en b", 32'(core_oe_en), 32'h0);
    endtask

    task automatic t_mode_off();
        pd_mode_en = 1'b0; pd_pin = 1'b1; in_pins = 8'h11; core_out = 8'h77;
        step(1);
        chk("R2 shared high", 32'(core_in), 32'h111);
        chk("R2 no freeze a", 32'(pin_out), 32'h77);
        in_pins = 8'h22; core_out = 8'h88;
        step(1);
        chk("R2 inputs flow", 32'(core_in), 32'h122);
        chk("R2 no freeze b", 32'(pin_out), 32'h88);
        pd_pin = 1'b0;
        step(1);
        chk("R2 shared low", 32'(core_in), 32'h022);
        pd_mode_en = 1'b1;
        step(1);
    endtask

    task automatic t_clock();
        clk_pin = 1'b1;
        step(1);
        chk("R4 tick on rise", 32'(core_tick), 32'h1);
        step(1);
        chk("R4 tick one cycle", 32'(core_tick), 32'h0);
        clk_pin = 1'b0;
        step(1);
        chk("R4 no tick on fall", 32'(core_tick), 32'h0);
        clk_pin = 1'b1;
        step(1);
        chk("R4 tick second rise", 32'(core_tick), 32'h1);
        clk_pin = 1'b0;
        step(1);
    endtask

    task automatic t_freeze_wake();
        in_pins = 8'h01; core_out = 8'h55; core_oe = 8'h0F; oe_pin = 1'b1;
        step(1);
        // Entry: the new values arrive together with the pin's rise.
        pd_pin = 1'b1; in_pins = 8'hFE; core_out = 8'hAA; core_oe = 8'hFF; oe_pin = 1'b0;
        step(1);
        chk("R11 entry input lost", 32'(core_in), 32'h001);
        chk("R11 entry output lost", 32'(pin_out), 32'h55);
        for (int i = 0; i < 6; i++) begin
            clk_pin = i[0];
            in_pins = 8'(i * 37 + 3);
            oe_pin  = i[1];
            core_out = 8'(i * 11);
            step(1);
            chk("R5 pin_out held", 32'(pin_out), 32'h55);
            chk("R6 hi-z kept", 32'(pin_oe), 32'h0F);
            chk("R7 core_in held", 32'(core_in), 32'h001);
            chk("R7 oe held", 32'(core_oe_en), 32'h1);
            chk("R7 no tick", 32'(core_tick), 32'h0);
        end
        // Release with clk_pin already high, so no tick may follow (R8).
        pd_pin = 1'b0; in_pins = 8'h3E; oe_pin = 1'b0; core_out = 8'hAA; core_oe = 8'hFF;
        for (int k = 1; k <= OUT_DLY + 2; k++) begin
            step(1);
            if (k <= CTL_DLY) begin
                chk("R9 inputs still blocked", 32'(core_in), 32'h001);
                chk("R9 oe still blocked", 32'(core_oe_en), 32'h1);
            end else begin
                chk("R9 inputs released", 32'(core_in), 32'h03E);
                chk("R9 oe released", 32'(core_oe_en), 32'h0);
            end
            if (k <= OUT_DLY) begin
                chk("R9 outputs still held", 32'(pin_out), 32'h55);
                chk("R6 hi-z until release", 32'(pin_oe), 32'h0F);
            end else begin
                chk("R9 outputs released", 32'(pin_out), 32'hAA);
                chk("R9 enables released", 32'(pin_oe), 32'hFF);
            end
            chk("R8 no late tick", 32'(core_tick), 32'h0);
        end
        clk_pin = 1'b0;
        step(1);
    endtask

    task automatic t_rewake();
        core_out = 8'h12;
        step(1);
        chk("R3 before rewake", 32'(pin_out), 32'h12);
        pd_pin = 1'b1; core_out = 8'h34;
        step(1);
        pd_pin = 1'b0;
        step(1);
        chk("R10 first wake held", 32'(pin_out), 32'h12);
        pd_pin = 1'b1;
        step(1);
        chk("R10 pulse held", 32'(pin_out), 32'h12);
        pd_pin = 1'b0;
        for (int k = 1; k <= OUT_DLY + 1; k++) begin
            step(1);
            if (k <= OUT_DLY)
                chk("R10 count restarted", 32'(pin_out), 32'h12);
            else
                chk("R10 released after restart", 32'(pin_out), 32'h34);
        end
    endtask

    initial begin
        step(1);
        t_reset();
        t_pass();
        t_mode_off();
        t_clock();
        t_freeze_wake();
        t_rewake();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule